// File: doc/BRIEF.md
# Addressable RGB LED Serial Encoder

This block turns 24-bit pixel words into the pulse-width-coded stream that a chain of single-wire addressable RGB LEDs expects. Every bit occupies one fixed-length slot. The slot opens with a high pulse whose length tells the LED whether the bit is a one or a zero, and the line then stays low for the rest of the slot. All phase lengths are integer counts of the system clock. They are chosen so that each pulse stays inside the LED's tolerance windows when the clock runs anywhere from 10% slow to 10% fast. The parameter check works from the shortest and longest possible clock periods rather than from the nominal period. A parameter set that misses a window stops elaboration.

A producer hands over pixel words through a valid/ready handshake. The encoder only takes a word when it is idle, when it is waiting in the inter-frame gap, or in the final cycle of the word it is currently sending. This keeps back-to-back words seamless. If no word arrives in time, the line simply stays low longer, which the LEDs tolerate. Once the line has stayed low for the latch threshold, a one-cycle frame-done pulse marks the end of the frame.

With the channel-count parameter set to two, a single slot and phase engine drives two pins. Each pin has its own data, and every slot starts on the same clock on both pins. A one and a zero share a common slot length, so the low tail of a zero is a little longer than its minimum.

Top module: `led_chain_encoder`

## Requirements
- R1: After reset, every LED output is low, pix_ready_o is high and frame_done_o is low.
- R2: A one bit is a high pulse of exactly T1H cycles (default 6). When another bit follows, it is followed by SLOT-T1H low cycles (default 5), where SLOT = max(T1H+T1L, T0H+T0L) = 11.
- R3: A zero bit is a high pulse of exactly T0H cycles (default 3). When another bit follows, it is followed by SLOT-T0H low cycles (default 8).
- R4: Each channel sends its 24-bit word most significant bit first. Bits 23:16 carry green, 15:8 red and 7:0 blue.
- R5: When the next word is offered by the last cycle of the current word, pix_ready_o is high in that cycle. The new word's first pulse then starts on the next cycle, with no extra low time at the word boundary.
- R6: A word accepted during the inter-frame gap, before the latch threshold is reached, continues the same frame. The only effect is a longer low time, and no frame_done_o pulse occurs.
- R7: frame_done_o pulses high for exactly one cycle. The pulse comes in the cycle when the line has been low for the last bit's low tail plus LATCH_CYC cycles (default 448). After it, the line stays low and pix_ready_o is high.
- R8: Channel c takes pix_data_i[24c+23:24c]. Channels carry independent data, and their rising edges always fall in the same cycle.
- R9: While a word is being sent and before its last cycle, pix_ready_o is low. A valid word offered in that interval is not taken and does not appear on the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_valid_i | input | 1 | Pixel word offered |
| pix_ready_o | output | 1 | Encoder takes the offered word at this edge |
| pix_data_i | input | NUM_CH*24 | One 24-bit pixel word per channel, channel 0 in the low bits |
| led_o | output | NUM_CH | Serial data line per LED chain |
| frame_done_o | output | 1 | One-cycle pulse after the latch gap |

## Verification
Several properties are checked by assertions on every cycle: every high pulse on a pin ends after exactly the one-length or the zero-length, the low time before a rising edge never drops below the shortest legal tail, the channels rise together, and frame-done is a single-cycle pulse that only follows a long enough low stretch. Other behaviour can only be shown by the bench's directed scenarios. These include the bit order and decoded word contents, seamless joins between back-to-back words, a late word continuing the frame without a latch, the exact cycle of the frame-done pulse, and words being refused in the middle of a transfer.

// File: rtl/led_enc_pkg.sv
package led_enc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } enc_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/led_bit_timer.sv
module led_bit_timer #(
  parameter int unsigned SLOT  = 11,
  parameter int unsigned PIX_W = 24,
  localparam int unsigned PH_W  = $clog2(SLOT),
  localparam int unsigned BIT_W = $clog2(PIX_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            run_i,
  output logic [PH_W-1:0] phase_o,
  output logic            slot_end_o,
  output logic            word_end_o
);

  logic [PH_W-1:0]  phase_q;
  logic [BIT_W-1:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
      bit_q   <= '0;
    end else if (start_i) begin
      phase_q <= '0;
      bit_q   <= '0;
    end else if (run_i) begin
      if (phase_q == PH_W'(SLOT - 1)) begin
        phase_q <= '0;
        bit_q   <= (bit_q == BIT_W'(PIX_W - 1)) ? '0 : bit_q + 1'b1;
      end else begin
        phase_q <= phase_q + 1'b1;
      end
    end
  end

  assign phase_o    = phase_q;
  assign slot_end_o = run_i && (phase_q == PH_W'(SLOT - 1));
  assign word_end_o = slot_end_o && (bit_q == BIT_W'(PIX_W - 1));

endmodule

// File: rtl/led_frame_ctrl.sv
module led_frame_ctrl
  import led_enc_pkg::*;
#(
  parameter int unsigned LATCH_CYC = 448,
  localparam int unsigned GAP_W = $clog2(LATCH_CYC + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic word_end_i,
  output logic ready_o,
  output logic load_o,
  output logic sending_o,
  output logic frame_done_o
);

  enc_state_e       state_q;
  logic [GAP_W-1:0] gap_q;
  logic             gap_last;

  assign gap_last     = (gap_q == GAP_W'(LATCH_CYC - 1));
  // word boundary only: keeps bit stream continuous inside a frame
  assign ready_o      = (state_q == ST_IDLE) || (state_q == ST_GAP) || word_end_i;
  assign load_o       = valid_i && ready_o;
  assign sending_o    = (state_q == ST_SEND);
  assign frame_done_o = (state_q == ST_GAP) && gap_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      gap_q   <= '0;
    end else if (load_o) begin
      state_q <= ST_SEND;
    end else begin
      unique case (state_q)
        ST_SEND: if (word_end_i) begin
          state_q <= ST_GAP;
          gap_q   <= '0;
        end
        ST_GAP: begin
          if (gap_last) state_q <= ST_IDLE;
          else          gap_q   <= gap_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o) else $error("frame_done longer than one cycle"); // R7

endmodule

// File: rtl/led_chan_shifter.sv
module led_chan_shifter #(
  parameter int unsigned PIX_W = 24,
  parameter int unsigned T1H   = 6,
  parameter int unsigned T0H   = 3,
  parameter int unsigned SLOT  = 11,
  localparam int unsigned PH_W = $clog2(SLOT),
  localparam int unsigned RC_W = $clog2(SLOT + 1) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PIX_W-1:0] data_i,
  input  logic             slot_end_i,
  input  logic             sending_i,
  input  logic [PH_W-1:0]  phase_i,
  output logic             led_o
);

  localparam logic [PH_W:0] HI_ONE  = (PH_W + 1)'(T1H);
  localparam logic [PH_W:0] HI_ZERO = (PH_W + 1)'(T0H);

  logic [PIX_W-1:0] sh_q;
  logic [PH_W:0]    hi_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sh_q <= '0;
    else if (load_i)     sh_q <= data_i;
    else if (slot_end_i) sh_q <= {sh_q[PIX_W-2:0], 1'b0};
  end

  assign hi_len = sh_q[PIX_W-1] ? HI_ONE : HI_ZERO;
  assign led_o  = sending_i && ({1'b0, phase_i} < hi_len);

  // pulse-width monitors
  logic [RC_W-1:0] hi_run_q, lo_run_q;
  logic            seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q <= '0;
      lo_run_q <= '0;
      seen_q   <= 1'b0;
    end else if (led_o) begin
      lo_run_q <= '0;
      seen_q   <= 1'b1;
      if (hi_run_q != '1) hi_run_q <= hi_run_q + 1'b1;
    end else begin
      hi_run_q <= '0;
      if (lo_run_q != '1) lo_run_q <= lo_run_q + 1'b1;
    end
  end

  AST_HIGH_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(led_o) |-> (hi_run_q == RC_W'(T1H) || hi_run_q == RC_W'(T0H)))
    else $error("high pulse width illegal"); // R2, R3

  AST_LOW_MIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(led_o) && seen_q) |-> (lo_run_q >= RC_W'(SLOT - T1H)))
    else $error("low tail too short"); // R5

endmodule

// File: rtl/led_chain_encoder.sv
module led_chain_encoder
  import led_enc_pkg::*;
#(
  parameter int unsigned NUM_CH         = 2,
  parameter int unsigned PIX_W          = 24,
  parameter int unsigned T1H            = 6,
  parameter int unsigned T1L            = 5,
  parameter int unsigned T0H            = 3,
  parameter int unsigned T0L            = 6,
  parameter int unsigned LATCH_CYC      = 448,
  parameter int unsigned CLK_MIN_NS     = 112,
  parameter int unsigned CLK_MAX_NS     = 138,
  parameter int unsigned ONE_HI_MIN_NS  = 550,
  parameter int unsigned ONE_HI_MAX_NS  = 850,
  parameter int unsigned ONE_LO_MIN_NS  = 450,
  parameter int unsigned ONE_LO_MAX_NS  = 750,
  parameter int unsigned ZERO_HI_MIN_NS = 200,
  parameter int unsigned ZERO_HI_MAX_NS = 500,
  parameter int unsigned ZERO_LO_MIN_NS = 650,
  parameter int unsigned ZERO_LO_MAX_NS = 950,
  parameter int unsigned LO_STRETCH_NS  = 200,
  parameter int unsigned LATCH_MIN_NS   = 50000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    pix_valid_i,
  output logic                    pix_ready_o,
  input  logic [NUM_CH*PIX_W-1:0] pix_data_i,
  output logic [NUM_CH-1:0]       led_o,
  output logic                    frame_done_o
);

  localparam int unsigned SLOT   = max2(T1H + T1L, T0H + T0L);
  localparam int unsigned PH_W   = $clog2(SLOT);
  localparam int unsigned ONE_LO = SLOT - T1H;
  localparam int unsigned ZERO_LO = SLOT - T0H;
  localparam int unsigned LC_W   = $clog2(LATCH_CYC + SLOT + 2);

  // elaboration-time window checks against slowest and fastest clock
  if (T1H * CLK_MIN_NS < ONE_HI_MIN_NS || T1H * CLK_MAX_NS > ONE_HI_MAX_NS) begin : g_bad_one_hi
    $error("one-bit high phase misses its window");
  end
  if (ONE_LO * CLK_MIN_NS < ONE_LO_MIN_NS || ONE_LO * CLK_MAX_NS > ONE_LO_MAX_NS) begin : g_bad_one_lo
    $error("one-bit low phase misses its window");
  end
  if (T0H * CLK_MIN_NS < ZERO_HI_MIN_NS || T0H * CLK_MAX_NS > ZERO_HI_MAX_NS) begin : g_bad_zero_hi
    $error("zero-bit high phase misses its window");
  end
  if (ZERO_LO * CLK_MIN_NS < ZERO_LO_MIN_NS ||
      ZERO_LO * CLK_MAX_NS > ZERO_LO_MAX_NS + LO_STRETCH_NS) begin : g_bad_zero_lo
    $error("zero-bit low phase misses its window");
  end
  if (LATCH_CYC * CLK_MIN_NS < LATCH_MIN_NS || T1H <= T0H) begin : g_bad_misc
    $error("latch gap too short or symbol lengths not distinct");
  end

  logic            load, sending, slot_end, word_end;
  logic [PH_W-1:0] phase;

  led_frame_ctrl #(.LATCH_CYC(LATCH_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (pix_valid_i),
    .word_end_i   (word_end),
    .ready_o      (pix_ready_o),
    .load_o       (load),
    .sending_o    (sending),
    .frame_done_o (frame_done_o)
  );

  led_bit_timer #(.SLOT(SLOT), .PIX_W(PIX_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (load),
    .run_i      (sending),
    .phase_o    (phase),
    .slot_end_o (slot_end),
    .word_end_o (word_end)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    led_chan_shifter #(
      .PIX_W (PIX_W),
      .T1H   (T1H),
      .T0H   (T0H),
      .SLOT  (SLOT)
    ) u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (load),
      .data_i     (pix_data_i[c*PIX_W +: PIX_W]),
      .slot_end_i (slot_end),
      .sending_i  (sending),
      .phase_i    (phase),
      .led_o      (led_o[c])
    );
  end

  for (genvar c = 1; c < NUM_CH; c++) begin : g_align
    AST_CH_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(led_o[c]) |-> $rose(led_o[0])) else $error("channel rise misaligned"); // R8
  end

  logic [LC_W-1:0] low_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                low_run_q <= '0;
    else if (led_o[0])          low_run_q <= '0;
    else if (low_run_q != '1)   low_run_q <= low_run_q + 1'b1;
  end

  AST_DONE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (!led_o[0] && low_run_q >= LC_W'(LATCH_CYC)))
    else $error("frame_done before latch gap elapsed"); // R7

endmodule

// File: tb/led_chain_encoder_tb.sv
module led_chain_encoder_tb;

  localparam int T1H   = 6;
  localparam int T0H   = 3;
  localparam int SLOT  = 11;
  localparam int LATCH = 448;
  localparam int DEPTH = 512;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pix_valid_i = 1'b0;
  logic [47:0] pix_data_i = '0;
  logic        pix_ready_o;
  logic [1:0]  led_o;
  logic        frame_done_o;

  always #2 clk_i = ~clk_i;

  led_chain_encoder u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .pix_valid_i  (pix_valid_i),
    .pix_ready_o  (pix_ready_o),
    .pix_data_i   (pix_data_i),
    .led_o        (led_o),
    .frame_done_o (frame_done_o)
  );

  int checks = 0;
  int errors = 0;

  // line monitor: high widths per bit, low run after each bit
  int   hw [2][DEPTH];
  int   lw [2][DEPTH];
  int   nb [2];
  int   run [2];
  logic prev [2];
  int   ndone = 0;
  int   done_low = 0;
  int   rise_mis = 0;
  int   cyc = 0;

  initial begin
    for (int c = 0; c < 2; c++) begin
      nb[c] = 0; run[c] = 0; prev[c] = 1'b0;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if ((led_o[0] && !prev[0]) != (led_o[1] && !prev[1])) rise_mis++;
      for (int c = 0; c < 2; c++) begin
        if (led_o[c] != prev[c]) begin
          if (prev[c]) begin
            if (nb[c] < DEPTH) begin hw[c][nb[c]] = run[c]; nb[c]++; end
          end else if (nb[c] > 0) begin
            lw[c][nb[c]-1] = run[c];
          end
          run[c] = 1;
        end else begin
          run[c]++;
        end
        prev[c] = led_o[c];
      end
      if (frame_done_o) begin
        ndone++;
        done_low = run[0];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] word_at(input int c, input int first);
    logic [23:0] w = '0;
    for (int i = 0; i < 24; i++) w = {w[22:0], (hw[c][first+i] == T1H)};
    return w;
  endfunction

  function automatic int bad_hi(input int c, input int first, input int n);
    int bad = 0;
    for (int i = first; i < first + n; i++)
      if (hw[c][i] != T1H && hw[c][i] != T0H) bad++;
    return bad;
  endfunction

  // low runs between consecutive bits first..first+n-1 (skip index 'skip')
  function automatic int bad_lo(input int c, input int first, input int n, input int skip);
    int bad = 0;
    for (int i = first; i < first + n - 1; i++) begin
      if (i != skip) begin
        if (lw[c][i] != ((hw[c][i] == T1H) ? SLOT - T1H : SLOT - T0H)) bad++;
      end
    end
    return bad;
  endfunction

  task automatic send_word(input logic [23:0] d0, input logic [23:0] d1);
    pix_data_i  = {d1, d0};
    pix_valid_i = 1'b1;
    while (!pix_ready_o) @(negedge clk_i);
    @(negedge clk_i);
    pix_valid_i = 1'b0;
  endtask

  task automatic wait_done(input int base);
    int t = 0;
    while (ndone == base && t < 4000) begin
      @(negedge clk_i);
      t++;
    end
    repeat (6) @(negedge clk_i);
  endtask

  task automatic t_reset();
    chk(led_o == 2'b00, "R1", "led after reset", led_o, 0);
    chk(pix_ready_o == 1'b1, "R1", "ready after reset", pix_ready_o, 1);
    chk(frame_done_o == 1'b0, "R1", "done after reset", frame_done_o, 0);
  endtask

  task automatic t_single();
    int b0 = nb[0], b1 = nb[1], bd = ndone, rm = rise_mis;
    send_word(24'hA5C3F0, 24'h0F1E2D);
    wait_done(bd);
    chk(nb[0] - b0 == 24, "R4", "bit count ch0", nb[0] - b0, 24);
    chk(word_at(0, b0) == 24'hA5C3F0, "R4", "msb-first word ch0", word_at(0, b0), 24'hA5C3F0);
    chk(word_at(1, b1) == 24'h0F1E2D, "R8", "independent word ch1", word_at(1, b1), 24'h0F1E2D);
    chk(bad_hi(0, b0, 24) + bad_hi(1, b1, 24) == 0, "R2 R3", "high widths",
        bad_hi(0, b0, 24) + bad_hi(1, b1, 24), 0);
    chk(bad_lo(0, b0, 24, -1) == 0, "R3", "low tails ch0", bad_lo(0, b0, 24, -1), 0);
    chk(ndone - bd == 1, "R7", "single done pulse", ndone - bd, 1);
    chk(done_low == SLOT - T0H + LATCH, "R7", "done cycle", done_low, SLOT - T0H + LATCH);
    chk(pix_ready_o && led_o == 2'b00, "R7", "idle after done", {pix_ready_o, led_o}, 3'b100);
    chk(rise_mis == rm, "R8", "rise alignment", rise_mis - rm, 0);
  endtask

  task automatic t_back_to_back();
    int b0 = nb[0], b1 = nb[1], bd = ndone;
    logic [23:0] w0 [3] = '{24'h123456, 24'hFFFFFF, 24'h800001};
    logic [23:0] w1 [3] = '{24'h000000, 24'hABCDEF, 24'h7E7E7E};
    for (int k = 0; k < 3; k++) send_word(w0[k], w1[k]);
    wait_done(bd);
    chk(nb[0] - b0 == 72, "R5", "bit count", nb[0] - b0, 72);
    for (int k = 0; k < 3; k++) begin
      chk(word_at(0, b0 + 24*k) == w0[k], "R5", "word ch0", word_at(0, b0 + 24*k), w0[k]);
      chk(word_at(1, b1 + 24*k) == w1[k], "R8", "word ch1", word_at(1, b1 + 24*k), w1[k]);
    end
    chk(bad_lo(0, b0, 72, -1) + bad_lo(1, b1, 72, -1) == 0, "R5", "no gap at boundary",
        bad_lo(0, b0, 72, -1) + bad_lo(1, b1, 72, -1), 0);
    chk(bad_hi(0, b0, 72) == 0, "R2", "high widths all-ones word", bad_hi(0, b0, 72), 0);
    chk(ndone - bd == 1, "R5", "one frame", ndone - bd, 1);
    chk(done_low == SLOT - T1H + LATCH, "R7", "done after one-bit tail", done_low, SLOT - T1H + LATCH);
  endtask

  task automatic t_late_word();
    int b0 = nb[0], bd = ndone;
    send_word(24'h00FF00, 24'h112233);
    while (!pix_ready_o) @(negedge clk_i);
    repeat (40) @(negedge clk_i);
    chk(ndone == bd, "R6", "no done before second word", ndone - bd, 0);
    send_word(24'hC0FFEE, 24'h445566);
    wait_done(bd);
    chk(ndone - bd == 1, "R6", "one frame only", ndone - bd, 1);
    chk(word_at(0, b0) == 24'h00FF00 && word_at(0, b0 + 24) == 24'hC0FFEE, "R6", "both words",
        word_at(0, b0 + 24), 24'hC0FFEE);
    chk(lw[0][b0+23] > SLOT - T0H && lw[0][b0+23] < LATCH, "R6", "stretched low", lw[0][b0+23], 48);
    chk(bad_lo(0, b0, 48, b0 + 23) == 0, "R2 R3", "tails away from boundary",
        bad_lo(0, b0, 48, b0 + 23), 0);
  endtask

  task automatic t_midword_ignore();
    int b0 = nb[0], bd = ndone;
    send_word(24'h5A5A5A, 24'hA5A5A5);
    repeat (5) @(negedge clk_i);
    chk(!pix_ready_o, "R9", "ready low mid-word", pix_ready_o, 0);
    pix_data_i  = {24'hDEAD00, 24'hBEEF00};
    pix_valid_i = 1'b1;
    repeat (100) @(negedge clk_i);
    chk(!pix_ready_o, "R9", "ready still low", pix_ready_o, 0);
    pix_valid_i = 1'b0;
    wait_done(bd);
    chk(nb[0] - b0 == 24, "R9", "no extra word", nb[0] - b0, 24);
    chk(word_at(0, b0) == 24'h5A5A5A, "R9", "word unchanged", word_at(0, b0), 24'h5A5A5A);
  endtask

  task automatic t_patterns();
    int b0 = nb[0], b1 = nb[1], bd = ndone, rm = rise_mis;
    send_word(24'hFFFFFF, 24'h000000);
    wait_done(bd);
    chk(word_at(0, b0) == 24'hFFFFFF, "R2", "all ones ch0", word_at(0, b0), 24'hFFFFFF);
    chk(word_at(1, b1) == 24'h000000, "R3", "all zeros ch1", word_at(1, b1), 24'h000000);
    chk(bad_lo(1, b1, 24, -1) == 0, "R3", "zero tails", bad_lo(1, b1, 24, -1), 0);
    chk(rise_mis == rm, "R8", "rise alignment mixed", rise_mis - rm, 0);
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 100000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=<100000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_single();
    t_back_to_back();
    t_late_word();
    t_midword_ignore();
    t_patterns();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule